// File: doc/BRIEF.md
# Buffered Flash Program Sequencer

This block is the device-side controller for a streaming, full-buffer programming mode on one block of a flash array. The host first writes a setup word and then a confirm word. The address on the confirm write gives the start word. The sequencer then spends one cycle checking the target block's lock input, the programming-voltage input and the alignment of the start address. If any check fails, it returns to ready with error flags set. If all checks pass, it accepts 32-word fills into an internal write buffer and commits each full buffer to the array through a write port.

While the mode is active, every bus write is treated as buffer data, including words that look like commands, and the status register is the only thing the host can read. Each commit writes 32 consecutive words, starting at an internal address counter that advances by 32 and wraps inside the block. A commit takes a fixed number of cycles. If a fill write targets a different block, the operation ends at once and the partial buffer is dropped. Writing the exit word as the first word of a fill ends the mode normally.

Top module: `bfp_seq`

## Requirements
- R1: After reset the status byte reads 0x80 (bit 7 = ready) and no array write is issued.
- R2: A write of 0x0080 followed by a write of 0x00D0 starts the mode. In the cycle after the confirm write the status is 0x00. Any other word in place of the confirm cancels the pair, and the status stays 0x80.
- R3: If the block-locked input is high during the check cycle, the status becomes ready with bit 4 (fail) and bit 1 (lock) set, which is 0x92. No array write follows.
- R4: If the voltage-valid input is low during the check cycle, the status becomes ready with bit 4 and bit 3 (voltage) set, which is 0x98.
- R5: If the start address has low five bits other than zero, the operation aborts with status 0x90.
- R6: When all checks pass, the status is 0x01 one cycle after the check: bit 7 low (busy) and bit 0 high (buffer free).
- R7: Fill words go to buffer offsets 0 to 31 in arrival order. Nothing is written to the array until the 32nd word arrives. The commit then writes word i to start address plus i.
- R8: After the 32nd fill write, bit 0 stays low for exactly PROG_CYC cycles and then the status returns to 0x01. Bus writes during that window are ignored.
- R9: A fill write whose address lies outside the block chosen at confirm aborts the mode with status 0x90. Words already buffered are never written to the array.
- R10: The internal word counter advances by 32 per commit and wraps to the first word of the same block after the block's last word.
- R11: A fill word equal to the read-status command value 0x0070 is stored and programmed as data.
- R12: The exit word 0x00FF, written as the first word of a fill, ends the mode with status 0x80 and programs nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Bus write strobe, one word per cycle |
| bus_addr_i | input | ADDR_W | Word address of the bus write |
| bus_data_i | input | DATA_W | Bus write data |
| blk_locked_i | input | 1 | Lock state of the addressed block, sampled in the check cycle |
| vpp_ok_i | input | 1 | Programming voltage valid, sampled in the check cycle |
| sr_o | output | 8 | Status register |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | ADDR_W | Array word address |
| arr_data_o | output | DATA_W | Array write data |

## Verification
The assertions assume three things about the host. It holds the lock and voltage inputs steady around the check cycle. It issues at most one bus write per cycle. During a commit it writes only while it is polling the buffer-free bit, and those writes are expected to be ignored. The stimulus follows the same discipline: every write lasts exactly one clock and is separated from the next by an idle cycle. Commits are awaited by polling bit 0, with a single deliberate write during one commit to show that it is dropped. Random data is drawn so that the first word of a fill never equals the exit word, except where the exit is intended.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CHECK,
    ST_FILL,
    ST_COMMIT
  } bfp_state_e;

  localparam int unsigned SR_RDY  = 7;
  localparam int unsigned SR_FAIL = 4;
  localparam int unsigned SR_VPP  = 3;
  localparam int unsigned SR_LOCK = 1;
  localparam int unsigned SR_BUF  = 0;
endpackage

// File: rtl/bfp_wbuf.sv
module bfp_wbuf #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [IDX_W-1:0]  cnt_o,
  output logic              last_o,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0]  cnt_q;
  logic              wr;

  assign wr = we_i && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cnt_q <= '0;
    else if (clr_i)                             cnt_q <= '0;
    else if (we_i) begin
      if (cnt_q == IDX_W'(DEPTH-1))             cnt_q <= '0;
      else                                      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr) mem_q[cnt_q] <= wdata_i;
  end

  assign cnt_o   = cnt_q;
  assign last_o  = wr && (cnt_q == IDX_W'(DEPTH-1));
  assign rdata_o = mem_q[ridx_i];

  // discarded fill leaves the buffer empty
  assert_clr_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  assert_fill_advance_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && cnt_q != IDX_W'(DEPTH-1)) |=> cnt_q != '0);
endmodule

// File: rtl/bfp_commit.sv
module bfp_commit #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned DEPTH    = 32,
  parameter int unsigned PROG_CYC = 40,
  localparam int unsigned IDX_W   = $clog2(DEPTH),
  localparam int unsigned T_W     = $clog2(PROG_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [IDX_W-1:0]  ridx_o,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_data_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [T_W-1:0] t_q;
  logic           busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      t_q    <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      t_q    <= '0;
    end else if (busy_q) begin
      if (t_q == T_W'(PROG_CYC-1)) busy_q <= 1'b0;
      t_q <= t_q + 1'b1;
    end
  end

  assign ridx_o     = t_q[IDX_W-1:0];
  assign arr_we_o   = busy_q && (t_q < T_W'(DEPTH));
  assign arr_addr_o = base_i + ADDR_W'(ridx_o);
  assign arr_data_o = rdata_i;
  assign busy_o     = busy_q;
  assign done_o     = busy_q && (t_q == T_W'(PROG_CYC-1));

  assert_commit_aligned_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && t_q == '0) |-> base_i[IDX_W-1:0] == '0);
  assert_base_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_o) |=> $stable(base_i));
  assert_no_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !start_i);
endmodule

// File: rtl/bfp_seq.sv
module bfp_seq
  import bfp_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned BLK_W    = 8,
  parameter int unsigned DEPTH    = 32,
  parameter int unsigned PROG_CYC = 40,
  parameter logic [DATA_W-1:0] CMD_SETUP   = DATA_W'('h0080),
  parameter logic [DATA_W-1:0] CMD_CONFIRM = DATA_W'('h00D0),
  parameter logic [DATA_W-1:0] EXIT_WORD   = DATA_W'('h00FF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              blk_locked_i,
  input  logic              vpp_ok_i,
  output logic [7:0]        sr_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_data_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned TAG_W = ADDR_W - BLK_W;

  bfp_state_e        state_q;
  logic [TAG_W-1:0]  tag_q;
  logic [BLK_W-1:0]  ptr_q;
  logic [7:0]        sr_q;

  logic              in_blk, is_exit, fill_wr, abort, buf_clr;
  logic [IDX_W-1:0]  cnt, ridx;
  logic              last;
  logic [DATA_W-1:0] rdata;
  logic              commit_busy, commit_done;
  logic              err_lock, err_vpp, err_align;

  assign in_blk    = bus_addr_i[ADDR_W-1:BLK_W] == tag_q;
  assign is_exit   = (cnt == '0) && (bus_data_i == EXIT_WORD);
  assign abort     = (state_q == ST_FILL) && bus_we_i && !in_blk;
  assign fill_wr   = (state_q == ST_FILL) && bus_we_i && in_blk && !is_exit;
  assign buf_clr   = abort || (state_q == ST_CHECK);
  assign err_lock  = blk_locked_i;
  assign err_vpp   = !vpp_ok_i;
  assign err_align = |ptr_q[IDX_W-1:0];

  bfp_wbuf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_wbuf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (buf_clr),
    .we_i    (fill_wr),
    .wdata_i (bus_data_i),
    .cnt_o   (cnt),
    .last_o  (last),
    .ridx_i  (ridx),
    .rdata_o (rdata)
  );

  bfp_commit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .PROG_CYC(PROG_CYC)) i_commit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (last),
    .base_i     ({tag_q, ptr_q}),
    .ridx_o     (ridx),
    .rdata_i    (rdata),
    .arr_we_o   (arr_we_o),
    .arr_addr_o (arr_addr_o),
    .arr_data_o (arr_data_o),
    .busy_o     (commit_busy),
    .done_o     (commit_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tag_q   <= '0;
      ptr_q   <= '0;
      sr_q    <= 8'h80;
    end else begin
      unique case (state_q)
        ST_IDLE: if (bus_we_i && bus_data_i == CMD_SETUP) state_q <= ST_SETUP;
        ST_SETUP: if (bus_we_i) begin
          if (bus_data_i == CMD_CONFIRM) begin
            state_q <= ST_CHECK;
            tag_q   <= bus_addr_i[ADDR_W-1:BLK_W];
            ptr_q   <= bus_addr_i[BLK_W-1:0];
            sr_q    <= 8'h00;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_CHECK: begin
          if (err_lock || err_vpp || err_align) begin
            state_q          <= ST_IDLE;
            sr_q             <= 8'h00;
            sr_q[SR_RDY]     <= 1'b1;
            sr_q[SR_FAIL]    <= 1'b1;
            sr_q[SR_VPP]     <= err_vpp;
            sr_q[SR_LOCK]    <= err_lock;
          end else begin
            state_q <= ST_FILL;
            sr_q    <= 8'h01;
          end
        end
        ST_FILL: if (bus_we_i) begin
          if (!in_blk) begin
            state_q <= ST_IDLE;
            sr_q    <= 8'h90;
          end else if (is_exit) begin
            state_q <= ST_IDLE;
            sr_q    <= 8'h80;
          end else if (last) begin
            state_q <= ST_COMMIT;
            sr_q    <= 8'h00;
          end
        end
        ST_COMMIT: if (commit_done) begin
          state_q <= ST_FILL;
          sr_q    <= 8'h01;
          ptr_q   <= ptr_q + BLK_W'(DEPTH);  // wraps inside the block
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sr_o = sr_q;

  assert_busy_in_mode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {ST_CHECK, ST_FILL, ST_COMMIT}) |-> !sr_q[SR_RDY]);
  assert_lock_report_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CHECK && blk_locked_i) |=> (sr_q[SR_LOCK] && sr_q[SR_FAIL] && sr_q[SR_RDY]));
  assert_vpp_report_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CHECK && !vpp_ok_i) |=> (sr_q[SR_VPP] && sr_q[SR_FAIL]));
  assert_buf_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_busy |-> !sr_q[SR_BUF]);
  assert_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> (sr_q == 8'h90 && !commit_busy && !arr_we_o));
  assert_no_write_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !arr_we_o);
endmodule

// File: tb/test_bfp_seq.sv
module test_bfp_seq;
  localparam int PROG_CYC = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        bus_we = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [15:0] bus_data = '0;
  logic        locked = 1'b0;
  logic        vpp_ok = 1'b1;
  logic [7:0]  sr;
  logic        arr_we;
  logic [9:0]  arr_addr;
  logic [15:0] arr_data;

  bfp_seq #(.PROG_CYC(PROG_CYC)) i_bfp_seq (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_data_i(bus_data), .blk_locked_i(locked), .vpp_ok_i(vpp_ok),
    .sr_o(sr), .arr_we_o(arr_we), .arr_addr_o(arr_addr), .arr_data_o(arr_data)
  );

  logic [15:0] mem     [1024];
  logic [15:0] exp_mem [1024];
  int unsigned wr_cnt = 0;
  always @(posedge clk) if (arr_we) begin
    mem[arr_addr] <= arr_data;
    wr_cnt <= wr_cnt + 1;
  end

  int vectors = 0;
  int errors  = 0;

  task automatic chk(input string req, input int unsigned act, input int unsigned exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sr_after_check(input logic lk, input logic vb, input logic mis);
    return {1'b1, 2'b00, lk | vb | mis, vb, 1'b0, lk, 1'b0};
  endfunction

  function automatic logic [9:0] word_addr(input logic [1:0] blk, input logic [7:0] start, input int idx);
    return {blk, 8'(int'(start) + idx)};
  endfunction

  task automatic wr(input logic [9:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_data = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic enter(input logic [1:0] blk, input logic [7:0] start);
    wr({blk, start}, 16'h0080);
    wr({blk, start}, 16'h00D0);
    chk("R2 busy after confirm", sr, 8'h00);
    @(negedge clk);
  endtask

  task automatic fill(input logic [1:0] blk, input logic [7:0] start, input int bufno,
                      input bit inject, input bit poke);
    int unsigned base;
    int c;
    base = wr_cnt;
    for (int i = 0; i < 32; i++) begin
      logic [15:0] d;
      d = 16'($urandom);
      if (i == 0 && d == 16'h00FF) d = 16'h1234;
      if (inject && i == 5) d = 16'h0070;
      exp_mem[word_addr(blk, start, bufno*32 + i)] = d;
      if (i == 31) chk("R7 no commit before full", wr_cnt - base, 0);
      wr({blk, 8'($urandom)}, d);
    end
    c = 0;
    if (poke) begin
      wr({~blk, 8'h00}, 16'h0080);
      c = 2;
      chk("R8 write during commit ignored", sr, 8'h00);
    end
    while (!sr[0] && c < 1000) begin
      @(negedge clk);
      c++;
    end
    chk("R8 commit latency", c, PROG_CYC);
    chk("R8 buffer free again", sr, 8'h01);
  endtask

  task automatic run_op(input logic [1:0] blk, input logic [7:0] start, input int nbuf,
                        input bit inject, input bit poke);
    int unsigned base;
    base = wr_cnt;
    enter(blk, start);
    chk("R6 ready for fill", sr, 8'h01);
    for (int b = 0; b < nbuf; b++) fill(blk, start, b, inject && b == 0, poke && b == 0);
    wr({blk, 8'h00}, 16'h00FF);
    chk("R12 exit to ready", sr, 8'h80);
    chk("R7 array write count", wr_cnt - base, 32 * nbuf);
    for (int i = 0; i < 32 * nbuf; i++) begin
      logic [9:0] a;
      a = word_addr(blk, start, i);
      chk("R7 array word", mem[a], exp_mem[a]);
    end
    if (inject) chk("R11 status command stored as data", mem[word_addr(blk, start, 5)], 16'h0070);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int unsigned base;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset status", sr, 8'h80);
    chk("R1 no write after reset", wr_cnt, 0);

    // R2: cancelled pair, lone confirm
    wr(10'h040, 16'h0080);
    wr(10'h040, 16'h0040);
    chk("R2 cancel keeps ready", sr, 8'h80);
    wr(10'h040, 16'h00D0);
    chk("R2 lone confirm ignored", sr, 8'h80);

    // R3 lock
    base = wr_cnt;
    locked = 1'b1;
    wr(10'h100, 16'h0080); wr(10'h100, 16'h00D0); @(negedge clk);
    chk("R3 locked block", sr, sr_after_check(1'b1, 1'b0, 1'b0));
    locked = 1'b0;
    // R4 voltage
    vpp_ok = 1'b0;
    wr(10'h100, 16'h0080); wr(10'h100, 16'h00D0); @(negedge clk);
    chk("R4 bad voltage", sr, sr_after_check(1'b0, 1'b1, 1'b0));
    vpp_ok = 1'b1;
    // R5 misaligned
    wr(10'h113, 16'h0080); wr(10'h113, 16'h00D0); @(negedge clk);
    chk("R5 misaligned start", sr, sr_after_check(1'b0, 1'b0, 1'b1));
    repeat (5) @(negedge clk);
    chk("R3 no array write on setup error", wr_cnt - base, 0);

    // R9 abort mid-fill
    base = wr_cnt;
    enter(2'd2, 8'h40);
    for (int i = 0; i < 10; i++) wr({2'd2, 8'($urandom)}, 16'($urandom));
    wr({2'd3, 8'h40}, 16'hABCD);
    chk("R9 abort status", sr, 8'h90);
    repeat (50) @(negedge clk);
    chk("R9 partial buffer dropped", wr_cnt - base, 0);

    // R10 wrap, with a poke during commit and a status-command word
    run_op(2'd1, 8'hE0, 2, 1'b1, 1'b1);
    chk("R10 wrap to block start", mem[{2'd1, 8'h00}], exp_mem[{2'd1, 8'h00}]);
    chk("R10 stayed in block", mem[{2'd1, 8'hFF}], exp_mem[{2'd1, 8'hFF}]);

    // R12 immediate exit programs nothing
    base = wr_cnt;
    run_op(2'd0, 8'h20, 0, 1'b0, 1'b0);
    chk("R12 exit writes nothing", wr_cnt - base, 0);

    // random operations
    for (int k = 0; k < 6; k++)
      run_op(2'($urandom), {3'($urandom), 5'b0}, 1 + int'($urandom % 3), k == 2, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule